// File: doc/BRIEF.md
# Result Retention Latch Buffer

This block is a small fully associative store that sits next to a reorder buffer whose result slots cannot be read for instruction issue. Every result the execution units write into a reorder-buffer slot is captured here in the same cycle, labelled with the slot's index. Only the newest handful of results are kept. When an issuing instruction needs a source operand that neither the forwarding network nor the committed register file can supply, it presents the slot index here and gets the value back combinationally. A miss tells the consumer to wait for the value to commit and read it from the register file.

Replacement is strictly by age of allocation, using a circular pointer. Two results written in one cycle take consecutive entries, with port 0 the older of the pair. A result written for a tag that is already held takes a fresh entry, and the older copy is dropped, so the held set is always exactly the most recent writes. Commit of a slot removes its copy, and a flush empties the whole buffer.

Top module: `rrb_retention_buf`

## Requirements
- R1: In the first cycle after reset is released, every lookup port with its request bit set reports a miss and no port reports a hit.
- R2: A result written on any write port with flush low is returned, with its data and a hit, by a lookup of its tag on any lookup port in the following cycles, until it is evicted, rewritten, committed or flushed.
- R3: A lookup whose tag equals the tag on a write port in the same cycle hits and returns that write's data in that cycle. The highest-numbered matching write port wins, and this bypass also works in a flush cycle.
- R4: For each lookup port, the hit flag and the miss flag are both 0 when the request bit is 0, and exactly one of them is 1 when it is set. The data output is 0 whenever the hit flag is 0.
- R5: The buffer holds the results of the most recent NUM_ENT allocations since reset or flush, and the next allocation evicts the oldest. Of two allocations in one cycle, port 0's is the older.
- R6: Writing a tag that is already held returns the new data on later lookups. The write takes a fresh entry and invalidates the old copy, so no two valid entries ever share a tag.
- R7: When two write ports carry the same tag in one cycle, only the higher-numbered port's data is kept, and it uses a single entry.
- R8: A commit of a tag removes its entry from the next cycle on, and a lookup in the commit cycle itself still hits. A write of the same tag in the commit cycle survives the commit.
- R9: Flush empties the buffer from the next cycle on, and writes presented in the flush cycle are not kept. The allocation order restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the buffer at the next edge |
| wr_vld_i | input | NUM_WR | Result write valid, one per write port |
| wr_tag_i | input | NUM_WR x TAG_W | Reorder-buffer slot index of each written result |
| wr_data_i | input | NUM_WR x DATA_W | Result value of each write port |
| cmt_vld_i | input | NUM_CMT | Slot commit valid, one per commit port |
| cmt_tag_i | input | NUM_CMT x TAG_W | Slot index being committed |
| rd_vld_i | input | NUM_RD | Operand lookup request, one per lookup port |
| rd_tag_i | input | NUM_RD x TAG_W | Slot index looked up |
| rd_hit_o | output | NUM_RD | Lookup found the value |
| rd_miss_o | output | NUM_RD | Lookup requested but the value is not held |
| rd_data_o | output | NUM_RD x DATA_W | Operand value on a hit, else 0 |

## Verification
The hardest situation to reach from the ports is eviction interleaved with rewrites and commits. An entry can be invalid yet still occupy its place in the allocation order, so the oldest live value survives longer than a naive count suggests. The bench first fills all eight entries with paired writes and checks the single and double evictions that follow. It then runs a long random phase over a narrow tag range, where rewrites, same-cycle same-tag writes, commits and rare flushes collide often. A behavioural history queue of allocations predicts every lookup on every clock.

// File: rtl/rrb_pkg.sv
// Package: default sizing shared by the retention buffer and its bench.
// Assumes nothing beyond the constants below being consistent with each other.
package rrb_pkg;
    localparam int unsigned RRB_ENTRIES = 8;   // power of two
    localparam int unsigned RRB_WR_PORTS = 2;
    localparam int unsigned RRB_RD_PORTS = 4;
    localparam int unsigned RRB_CMT_PORTS = 2;
    localparam int unsigned RRB_TAG_W = 6;
    localparam int unsigned RRB_DATA_W = 32;
endpackage

// File: rtl/rrb_alloc.sv
// Module: rrb_alloc
// Decides which write ports allocate an entry this cycle and which entry each
// one takes. A write is dropped if a higher-numbered port carries the same tag
// or flush is high. Surviving writes take consecutive entries from a circular
// pointer in port order. Assumes NUM_ENT is a power of two and NUM_WR <= NUM_ENT.
module rrb_alloc #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned NUM_WR  = 2,
    parameter int unsigned TAG_W   = 6,
    localparam int unsigned IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic [NUM_WR-1:0]             wr_vld_i,
    input  logic [NUM_WR-1:0][TAG_W-1:0]  wr_tag_i,
    output logic [NUM_WR-1:0]             wr_eff_o,
    output logic [NUM_WR-1:0][IDX_W-1:0]  wr_slot_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] alloc_cnt;

    // Purpose: drop writes superseded by a higher port with the same tag, or by flush.
    always_comb begin
        for (int i = 0; i < NUM_WR; i++) begin
            logic sup;
            sup = 1'b0;
            for (int j = 0; j < NUM_WR; j++) begin
                if (j > i && wr_vld_i[j] && wr_tag_i[j] == wr_tag_i[i]) begin
                    sup = 1'b1;
                end
            end
            wr_eff_o[i] = wr_vld_i[i] && !sup && !flush_i;
        end
    end

    // Purpose: assign consecutive entries to surviving writes in port order.
    always_comb begin
        logic [IDX_W-1:0] off;
        off = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            wr_slot_o[i] = ptr_q + off;
            if (wr_eff_o[i]) begin
                off = off + IDX_W'(1);
            end
        end
        alloc_cnt = off;
    end

    // Purpose: advance the circular pointer, restarting at entry 0 on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (flush_i) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + alloc_cnt;
        end
    end

endmodule

// File: rtl/rrb_store.sv
// Module: rrb_store
// Holds the entries: valid bit, tag and data each. An allocated entry is
// loaded and marked valid. Any other valid entry whose tag matches a surviving
// write or a commit is invalidated. Flush clears every valid bit. Assumes the
// allocator never targets one entry from two ports in the same cycle.
module rrb_store #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned NUM_WR  = 2,
    parameter int unsigned NUM_CMT = 2,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush_i,
    input  logic [NUM_WR-1:0]              wr_eff_i,
    input  logic [NUM_WR-1:0][IDX_W-1:0]   wr_slot_i,
    input  logic [NUM_WR-1:0][TAG_W-1:0]   wr_tag_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
    input  logic [NUM_CMT-1:0]             cmt_vld_i,
    input  logic [NUM_CMT-1:0][TAG_W-1:0]  cmt_tag_i,
    output logic [NUM_ENT-1:0]             ent_vld_o,
    output logic [NUM_ENT-1:0][TAG_W-1:0]  ent_tag_o,
    output logic [NUM_ENT-1:0][DATA_W-1:0] ent_data_o
);

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic              vld_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;
        logic              load;
        logic              kill;
        logic [TAG_W-1:0]  new_tag;
        logic [DATA_W-1:0] new_data;

        // Purpose: find a write allocating this entry and any write or commit staling it.
        always_comb begin
            load     = 1'b0;
            kill     = 1'b0;
            new_tag  = tag_q;
            new_data = data_q;
            for (int i = 0; i < NUM_WR; i++) begin
                if (wr_eff_i[i] && wr_slot_i[i] == IDX_W'(e)) begin
                    load     = 1'b1;
                    new_tag  = wr_tag_i[i];
                    new_data = wr_data_i[i];
                end
                if (wr_eff_i[i] && wr_tag_i[i] == tag_q) begin
                    kill = 1'b1;
                end
            end
            for (int k = 0; k < NUM_CMT; k++) begin
                if (cmt_vld_i[k] && cmt_tag_i[k] == tag_q) begin
                    kill = 1'b1;
                end
            end
        end

        // Purpose: update the entry; flush beats load, load beats invalidation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                tag_q  <= '0;
                data_q <= '0;
            end else if (flush_i) begin
                vld_q <= 1'b0;
            end else if (load) begin
                vld_q  <= 1'b1;
                tag_q  <= new_tag;
                data_q <= new_data;
            end else if (kill) begin
                vld_q <= 1'b0;
            end
        end

        assign ent_vld_o[e]  = vld_q;
        assign ent_tag_o[e]  = tag_q;
        assign ent_data_o[e] = data_q;
    end

endmodule

// File: rtl/rrb_lookup.sv
// Module: rrb_lookup
// One operand lookup port. It matches the tag against all valid entries, then
// lets a same-cycle write of that tag override the stored value (the highest
// write port wins). Assumes at most one valid entry carries any tag.
module rrb_lookup #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned NUM_WR  = 2,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                           rd_vld_i,
    input  logic [TAG_W-1:0]               rd_tag_i,
    input  logic [NUM_WR-1:0]              wr_vld_i,
    input  logic [NUM_WR-1:0][TAG_W-1:0]   wr_tag_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0]  wr_data_i,
    input  logic [NUM_ENT-1:0]             ent_vld_i,
    input  logic [NUM_ENT-1:0][TAG_W-1:0]  ent_tag_i,
    input  logic [NUM_ENT-1:0][DATA_W-1:0] ent_data_i,
    output logic                           hit_o,
    output logic                           miss_o,
    output logic [DATA_W-1:0]              data_o
);

    // Purpose: stored match, then same-cycle write bypass, then request gating.
    always_comb begin
        logic              h;
        logic [DATA_W-1:0] d;
        h = 1'b0;
        d = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (ent_vld_i[e] && ent_tag_i[e] == rd_tag_i) begin
                h = 1'b1;
                d = d | ent_data_i[e];
            end
        end
        for (int i = 0; i < NUM_WR; i++) begin
            if (wr_vld_i[i] && wr_tag_i[i] == rd_tag_i) begin
                h = 1'b1;
                d = wr_data_i[i];
            end
        end
        hit_o  = rd_vld_i && h;
        miss_o = rd_vld_i && !h;
        data_o = (rd_vld_i && h) ? d : '0;
    end

endmodule

// File: rtl/rrb_retention_buf.sv
// Module: rrb_retention_buf
// Fully associative buffer holding the most recent results written into the
// reorder buffer, looked up by slot index on several parallel ports in the same
// cycle. Assumes NUM_ENT is a power of two and at least NUM_WR.
module rrb_retention_buf
    import rrb_pkg::*;
#(
    parameter int unsigned NUM_ENT = RRB_ENTRIES,
    parameter int unsigned NUM_WR  = RRB_WR_PORTS,
    parameter int unsigned NUM_RD  = RRB_RD_PORTS,
    parameter int unsigned NUM_CMT = RRB_CMT_PORTS,
    parameter int unsigned TAG_W   = RRB_TAG_W,
    parameter int unsigned DATA_W  = RRB_DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic [NUM_WR-1:0]             wr_vld_i,
    input  logic [NUM_WR-1:0][TAG_W-1:0]  wr_tag_i,
    input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data_i,
    input  logic [NUM_CMT-1:0]            cmt_vld_i,
    input  logic [NUM_CMT-1:0][TAG_W-1:0] cmt_tag_i,
    input  logic [NUM_RD-1:0]             rd_vld_i,
    input  logic [NUM_RD-1:0][TAG_W-1:0]  rd_tag_i,
    output logic [NUM_RD-1:0]             rd_hit_o,
    output logic [NUM_RD-1:0]             rd_miss_o,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);

    localparam int unsigned IDX_W = $clog2(NUM_ENT);

    logic [NUM_WR-1:0]              wr_eff;
    logic [NUM_WR-1:0][IDX_W-1:0]   wr_slot;
    logic [NUM_ENT-1:0]             ent_vld;
    logic [NUM_ENT-1:0][TAG_W-1:0]  ent_tag;
    logic [NUM_ENT-1:0][DATA_W-1:0] ent_data;

    rrb_alloc #(
        .NUM_ENT (NUM_ENT),
        .NUM_WR  (NUM_WR),
        .TAG_W   (TAG_W)
    ) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .wr_vld_i  (wr_vld_i),
        .wr_tag_i  (wr_tag_i),
        .wr_eff_o  (wr_eff),
        .wr_slot_o (wr_slot)
    );

    rrb_store #(
        .NUM_ENT (NUM_ENT),
        .NUM_WR  (NUM_WR),
        .NUM_CMT (NUM_CMT),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .wr_eff_i   (wr_eff),
        .wr_slot_i  (wr_slot),
        .wr_tag_i   (wr_tag_i),
        .wr_data_i  (wr_data_i),
        .cmt_vld_i  (cmt_vld_i),
        .cmt_tag_i  (cmt_tag_i),
        .ent_vld_o  (ent_vld),
        .ent_tag_o  (ent_tag),
        .ent_data_o (ent_data)
    );

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        rrb_lookup #(
            .NUM_ENT (NUM_ENT),
            .NUM_WR  (NUM_WR),
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W)
        ) u_lookup (
            .rd_vld_i   (rd_vld_i[r]),
            .rd_tag_i   (rd_tag_i[r]),
            .wr_vld_i   (wr_vld_i),
            .wr_tag_i   (wr_tag_i),
            .wr_data_i  (wr_data_i),
            .ent_vld_i  (ent_vld),
            .ent_tag_i  (ent_tag),
            .ent_data_i (ent_data),
            .hit_o      (rd_hit_o[r]),
            .miss_o     (rd_miss_o[r]),
            .data_o     (rd_data_o[r])
        );
    end

endmodule

// File: rtl/rrb_checker.sv
// Module: rrb_checker
// Temporal checks on the retention buffer, bound to its top module. It sees
// the ports plus the entry valid bits and tags.
module rrb_checker #(
    parameter int unsigned NUM_ENT = 8,
    parameter int unsigned NUM_WR  = 2,
    parameter int unsigned NUM_RD  = 4,
    parameter int unsigned NUM_CMT = 2,
    parameter int unsigned TAG_W   = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush_i,
    input logic [NUM_WR-1:0]             wr_vld_i,
    input logic [NUM_WR-1:0][TAG_W-1:0]  wr_tag_i,
    input logic [NUM_CMT-1:0]            cmt_vld_i,
    input logic [NUM_CMT-1:0][TAG_W-1:0] cmt_tag_i,
    input logic [NUM_RD-1:0]             rd_vld_i,
    input logic [NUM_RD-1:0]             rd_hit_o,
    input logic [NUM_RD-1:0]             rd_miss_o,
    input logic [NUM_ENT-1:0]            ent_vld,
    input logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag
);

    function automatic logic held(input logic [NUM_ENT-1:0] v,
                                  input logic [NUM_ENT-1:0][TAG_W-1:0] t,
                                  input logic [TAG_W-1:0] q);
        logic f;
        f = 1'b0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (v[e] && t[e] == q) f = 1'b1;
        end
        return f;
    endfunction

    logic [NUM_CMT-1:0] cmt_alone;

    // Purpose: commits whose tag no write carries in the same cycle.
    always_comb begin
        for (int k = 0; k < NUM_CMT; k++) begin
            logic m;
            m = 1'b0;
            for (int i = 0; i < NUM_WR; i++) begin
                if (wr_vld_i[i] && wr_tag_i[i] == cmt_tag_i[k]) m = 1'b1;
            end
            cmt_alone[k] = cmt_vld_i[k] && !m;
        end
    end

    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (ent_vld == '0));

    p_hit_or_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hit_o | rd_miss_o) == rd_vld_i) && ((rd_hit_o & rd_miss_o) == '0));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ent_vld == '0));

    for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
        p_write_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld_i[w] && !flush_i) |=> held(ent_vld, ent_tag, $past(wr_tag_i[w])));
    end

    for (genvar k = 0; k < NUM_CMT; k++) begin : g_cmt
        p_commit_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cmt_alone[k] |=> !held(ent_vld, ent_tag, $past(cmt_tag_i[k])));
    end

    for (genvar a = 0; a < NUM_ENT; a++) begin : g_pa
        for (genvar b = a + 1; b < NUM_ENT; b++) begin : g_pb
            p_unique_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(ent_vld[a] && ent_vld[b] && ent_tag[a] == ent_tag[b]));
        end
    end

endmodule

bind rrb_retention_buf rrb_checker #(
    .NUM_ENT (NUM_ENT),
    .NUM_WR  (NUM_WR),
    .NUM_RD  (NUM_RD),
    .NUM_CMT (NUM_CMT),
    .TAG_W   (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .wr_vld_i  (wr_vld_i),
    .wr_tag_i  (wr_tag_i),
    .cmt_vld_i (cmt_vld_i),
    .cmt_tag_i (cmt_tag_i),
    .rd_vld_i  (rd_vld_i),
    .rd_hit_o  (rd_hit_o),
    .rd_miss_o (rd_miss_o),
    .ent_vld   (ent_vld),
    .ent_tag   (ent_tag)
);

// File: tb/tb_rrb_retention_buf.sv
// Bench: a history queue of allocations since reset or flush predicts every lookup.
module tb_rrb_retention_buf;
    import rrb_pkg::*;

    localparam int NE = RRB_ENTRIES;
    localparam int NW = RRB_WR_PORTS;
    localparam int NR = RRB_RD_PORTS;
    localparam int NC = RRB_CMT_PORTS;
    localparam int TW = RRB_TAG_W;
    localparam int DW = RRB_DATA_W;

    logic clk = 1'b0;
    logic rst_n;
    logic flush;
    logic [NW-1:0]         wr_vld;
    logic [NW-1:0][TW-1:0] wr_tag;
    logic [NW-1:0][DW-1:0] wr_data;
    logic [NC-1:0]         cmt_vld;
    logic [NC-1:0][TW-1:0] cmt_tag;
    logic [NR-1:0]         rd_vld;
    logic [NR-1:0][TW-1:0] rd_tag;
    logic [NR-1:0]         rd_hit;
    logic [NR-1:0]         rd_miss;
    logic [NR-1:0][DW-1:0] rd_data;

    typedef struct {
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
        bit            alive;
    } rec_t;
    rec_t hist[$];

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    rrb_retention_buf dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .wr_vld_i(wr_vld), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
        .cmt_vld_i(cmt_vld), .cmt_tag_i(cmt_tag),
        .rd_vld_i(rd_vld), .rd_tag_i(rd_tag),
        .rd_hit_o(rd_hit), .rd_miss_o(rd_miss), .rd_data_o(rd_data)
    );

    task automatic idle();
        flush = 0; wr_vld = '0; wr_tag = '0; wr_data = '0;
        cmt_vld = '0; cmt_tag = '0; rd_vld = '0; rd_tag = '0;
    endtask

    task automatic wr(int p, int t, logic [DW-1:0] d);
        wr_vld[p] = 1'b1; wr_tag[p] = TW'(t); wr_data[p] = d;
    endtask

    task automatic rd(int p, int t);
        rd_vld[p] = 1'b1; rd_tag[p] = TW'(t);
    endtask

    task automatic cmt(int p, int t);
        cmt_vld[p] = 1'b1; cmt_tag[p] = TW'(t);
    endtask

    // Expected lookup result: same-cycle writes (highest port) then newest live record.
    task automatic predict(int r, output bit eh, output logic [DW-1:0] ed);
        eh = 0; ed = '0;
        if (!rd_vld[r]) return;
        for (int i = NW - 1; i >= 0; i--) begin
            if (wr_vld[i] && wr_tag[i] == rd_tag[r]) begin
                eh = 1; ed = wr_data[i]; return;
            end
        end
        for (int k = hist.size() - 1; k >= 0; k--) begin
            if (hist[k].alive && hist[k].tag == rd_tag[r]) begin
                eh = 1; ed = hist[k].data; return;
            end
        end
    endtask

    task automatic kill_tag(logic [TW-1:0] t);
        foreach (hist[k]) if (hist[k].tag == t) hist[k].alive = 0;
    endtask

    task automatic model_step();
        if (flush) begin
            hist.delete();
            return;
        end
        for (int k = 0; k < NC; k++) if (cmt_vld[k]) kill_tag(cmt_tag[k]);
        for (int i = 0; i < NW; i++) begin
            bit sup;
            rec_t nr;
            sup = 0;
            for (int j = i + 1; j < NW; j++)
                if (wr_vld[j] && wr_tag[j] == wr_tag[i]) sup = 1;
            if (wr_vld[i] && !sup) begin
                kill_tag(wr_tag[i]);
                nr.tag = wr_tag[i]; nr.data = wr_data[i]; nr.alive = 1;
                hist.push_back(nr);
                if (hist.size() > NE) void'(hist.pop_front());
            end
        end
    endtask

    // One clock: compare all lookup ports 2 ns before the edge, advance the model.
    task automatic tick(string req);
        #2;
        for (int r = 0; r < NR; r++) begin
            bit eh;
            logic [DW-1:0] ed;
            predict(r, eh, ed);
            checks++;
            if (rd_hit[r] !== eh || rd_miss[r] !== (rd_vld[r] && !eh) || rd_data[r] !== ed) begin
                errors++;
                $display("FAIL %s port %0d tag %0d: hit=%b miss=%b data=%h expected hit=%b miss=%b data=%h",
                         req, r, rd_tag[r], rd_hit[r], rd_miss[r], rd_data[r],
                         eh, rd_vld[r] && !eh, ed);
            end
        end
        model_step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        rd(0, 0); rd(1, 5); rd(2, 17); rd(3, 63); tick("R1");

        // R2: capture and later lookup on every port
        wr(0, 3, 32'hA0A0_0003); tick("R2");
        for (int r = 0; r < NR; r++) rd(r, 3);
        tick("R2");

        // R3: same-cycle bypass, highest port wins
        wr(1, 9, 32'h9999_0009); rd(2, 9); rd(0, 3); tick("R3");
        wr(0, 22, 32'h1111_0001); wr(1, 22, 32'h2222_0002); rd(1, 22); tick("R3");

        // R4: no request gives neither flag, unknown tag gives miss
        rd_tag[0] = TW'(3); rd(1, 44); rd(2, 9); tick("R4");

        // R5: fill with paired writes, then single and double evictions
        flush = 1; tick("R9");
        for (int c = 0; c < 4; c++) begin
            wr(0, 10 + 2 * c, 32'h5000_0000 + 32'(2 * c));
            wr(1, 11 + 2 * c, 32'h5000_0000 + 32'(2 * c + 1));
            tick("R5");
        end
        for (int r = 0; r < NR; r++) rd(r, 10 + r);
        tick("R5");
        for (int r = 0; r < NR; r++) rd(r, 14 + r);
        tick("R5");
        wr(0, 18, 32'h5000_0018); tick("R5");
        rd(0, 10); rd(1, 11); rd(2, 18); rd(3, 17); tick("R5");
        wr(0, 19, 32'h5000_0019); wr(1, 20, 32'h5000_0020); tick("R5");
        rd(0, 11); rd(1, 12); rd(2, 13); rd(3, 20); tick("R5");

        // R6: rewrite of a held tag returns the newest value
        wr(0, 13, 32'h6666_0013); tick("R6");
        rd(0, 13); rd(1, 14); rd(2, 15); rd(3, 19); tick("R6");

        // R7: same tag on both write ports keeps the higher port
        wr(0, 40, 32'h7000_0000); wr(1, 40, 32'h7000_0001); rd(0, 40); tick("R7");
        rd(0, 40); rd(1, 16); rd(2, 17); rd(3, 18); tick("R7");

        // R8: commit takes effect next cycle; a same-cycle write survives it
        cmt(0, 40); rd(0, 40); tick("R8");
        rd(0, 40); tick("R8");
        wr(0, 41, 32'h8888_0041); cmt(1, 41); tick("R8");
        rd(0, 41); tick("R8");

        // R9: flush drops same-cycle writes but still bypasses them
        flush = 1; wr(0, 50, 32'h9000_0050); rd(0, 50); tick("R9");
        rd(0, 50); rd(1, 41); rd(2, 20); rd(3, 19); tick("R9");
        for (int c = 0; c < NE; c++) begin
            wr(0, 30 + c, 32'h9100_0000 + 32'(c)); tick("R9");
        end
        wr(0, 60, 32'h9100_0060); tick("R9");
        rd(0, 30); rd(1, 31); rd(2, 37); rd(3, 60); tick("R9");

        // R5: random mix of writes, rewrites, commits, lookups and rare flushes
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NW; i++)
                if ($urandom_range(0, 2) != 0)
                    wr(i, int'($urandom_range(0, 15)), 32'($urandom));
            for (int k = 0; k < NC; k++)
                if ($urandom_range(0, 3) == 0) cmt(k, int'($urandom_range(0, 15)));
            for (int r = 0; r < NR; r++)
                if ($urandom_range(0, 3) != 0) rd(r, int'($urandom_range(0, 15)));
            flush = ($urandom_range(0, 63) == 0);
            tick("R5");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule